// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit timer channel. It counts input ticks from a loaded start value and shapes a single output level according to one of six operating modes: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square wave, and two strobe variants. A register front end (not part of this block) writes a mode number and a count value through two single-cycle write strobes. The channel presents the live count and the output level continuously.

The `tick` input is a one-cycle enable that marks the counting rate. The `gate` input either pauses counting or restarts the channel on its rising edge, depending on the mode. The count value 0 stands for the largest period, 65536 ticks. Until a mode is first written, the channel ignores ticks and holds its output low.

Top module: `interval_counter`

## Requirements
- R1: A loaded count of 0 acts as 65536. The readout shows 0x0000 right after the load. In mode 0, `out` rises only after the 65536th tick.
- R2: Mode numbers 6 and 7 behave exactly like modes 2 and 3.
- R3: A count write restarts the channel. In the next cycle `count_now` equals the written value, whatever the mode. A tick in the same cycle as the write is not counted, so the first decrement comes with the next tick.
- R4: Mode 0: `out` is low after a load and rises when the number of counted ticks reaches the loaded count N. It then stays high until the next restart. The readout decrements by one per tick and wraps from 0x0000 to 0xFFFF.
- R5: In modes 0 and 4, ticks are counted only while `gate` is high. While `gate` is low, `count_now` holds.
- R6: Mode 1: `out` is high from a restart until N ticks have been counted, then low. A rising edge of `gate` restarts the channel from N, even when a tick arrives in the same cycle.
- R7: Mode 2: the readout runs N, N-1, ..., 1 and then reloads to N. `out` is high only while the readout is N after at least one tick has passed since the restart. A rising edge of `gate` restarts the channel.
- R8: Mode 3: with position p = ticks mod N, `out` is high while p < (N+1)/2 (integer division) and low for the rest of the period. The readout is N - (2p mod N), so it drops by two per tick.
- R9: Modes 4 and 5: `out` is high only while exactly N ticks have been counted. In mode 5, a rising edge of `gate` restarts the channel.
- R10: After reset, no mode is set: `out` is low, `count_now` is 0x0000 (reload 65536), and ticks are ignored.
- R11: A mode write restarts the channel from the reload value already held, and it marks the channel configured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one per counting step |
| gate | input | 1 | Gate level: pauses counting in modes 0/4, rising edge restarts in modes 1/2/3/5 |
| mode_we | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode number 0..7 (6 and 7 fold onto 2 and 3) |
| count_we | input | 1 | Count write strobe |
| count_val | input | 16 | Count value, 0 meaning 65536 |
| count_now | output | 16 | Live count readout |
| out | output | 1 | Mode-shaped output level |

## Verification
A restart and a tick can land in the same cycle. A restart comes from a count write, a mode write or a retriggering gate edge. The bench raises `tick` together with `count_we`, and separately together with a rising `gate` in modes 1, 2 and 5. It then requires the readout in the following cycle to be exactly the reload value, with no decrement. A second collision is a tick while the gate is low in the gated modes. There the readout must hold across every such cycle, which is judged against a reference model that counts elapsed ticks independently of the design's phase logic.

// File: rtl/ict_pkg.sv
package ict_pkg;

    typedef enum logic [2:0] {
        MODE_TERM     = 3'd0,
        MODE_ONESHOT  = 3'd1,
        MODE_RATE     = 3'd2,
        MODE_SQUARE   = 3'd3,
        MODE_SWSTROBE = 3'd4,
        MODE_HWSTROBE = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        PH_BEFORE = 2'd0,
        PH_AT     = 2'd1,
        PH_AFTER  = 2'd2
    } phase_e;

    // Codes 6 and 7 fold onto the rate and square modes.
    function automatic mode_e fold_mode(logic [2:0] v);
        return (v > 3'd5) ? mode_e'(v - 3'd4) : mode_e'(v);
    endfunction

    function automatic logic is_retrig(mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_RATE) ||
               (m == MODE_SQUARE)  || (m == MODE_HWSTROBE);
    endfunction

    function automatic logic is_gated(mode_e m);
        return (m == MODE_TERM) || (m == MODE_SWSTROBE);
    endfunction

    function automatic logic is_periodic(mode_e m);
        return (m == MODE_RATE) || (m == MODE_SQUARE);
    endfunction

endpackage

// File: rtl/ict_ctrl.sv
module ict_ctrl
    import ict_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             mode_we,
    input  logic [2:0]       mode_sel,
    input  logic             count_we,
    input  logic [CNT_W-1:0] count_val,
    output logic             cfg_valid,
    output mode_e            mode,
    output logic [CNT_W:0]   reload,
    output logic             restart,
    output logic             advance
);
    localparam int NW = CNT_W + 1;
    localparam logic [NW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

    logic gate_q;
    logic gate_rise;

    always_comb begin
        gate_rise = gate & ~gate_q;
        restart   = count_we | mode_we | (gate_rise & cfg_valid & is_retrig(mode));
        advance   = tick & cfg_valid & ~restart & (gate | ~is_gated(mode));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q    <= 1'b0;
            cfg_valid <= 1'b0;
            mode      <= MODE_TERM;
            reload    <= FULL;
        end else begin
            gate_q <= gate;
            if (mode_we) begin
                cfg_valid <= 1'b1;
                mode      <= fold_mode(mode_sel);
            end
            if (count_we) begin
                reload <= (count_val == '0) ? FULL : {1'b0, count_val};
            end
        end
    end

endmodule

// File: rtl/ict_core.sv
module ict_core
    import ict_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic           advance,
    input  mode_e          mode,
    input  logic [CNT_W:0] reload,
    output logic [CNT_W:0] pos,
    output phase_e         phase,
    output logic           started
);
    localparam int NW = CNT_W + 1;
    localparam logic [NW:0] ONE_W = 1;

    logic [NW:0] pos_inc;
    logic        hit;

    always_comb begin
        pos_inc = {1'b0, pos} + ONE_W;
        hit     = (pos_inc == {1'b0, reload});
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos     <= '0;
            phase   <= PH_BEFORE;
            started <= 1'b0;
        end else if (advance) begin
            if (is_periodic(mode)) begin
                // Position wraps within the period.
                pos     <= hit ? '0 : pos_inc[NW-1:0];
                started <= 1'b1;
            end else begin
                // Free-running elapsed count plus terminal phase.
                pos <= pos_inc[NW-1:0];
                unique case (phase)
                    PH_BEFORE: if (hit) phase <= PH_AT;
                    PH_AT:     phase <= PH_AFTER;
                    default:   phase <= PH_AFTER;
                endcase
            end
        end
    end

endmodule

// File: rtl/ict_shape.sv
module ict_shape
    import ict_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             cfg_valid,
    input  mode_e            mode,
    input  logic [CNT_W:0]   reload,
    input  logic [CNT_W:0]   pos,
    input  phase_e           phase,
    input  logic             started,
    output logic [CNT_W-1:0] count_now,
    output logic             out
);
    localparam int NW = CNT_W + 1;
    localparam logic [NW:0] ONE_W = 1;

    logic [NW:0]      half;
    logic [NW:0]      dbl;
    logic             dbl_ge;
    logic [CNT_W-1:0] fold_lo;
    logic [CNT_W-1:0] lin_cnt;
    logic [CNT_W-1:0] sq_cnt;

    always_comb begin
        half    = ({1'b0, reload} + ONE_W) >> 1;
        dbl     = {pos, 1'b0};
        dbl_ge  = (dbl >= {1'b0, reload});
        fold_lo = dbl_ge ? (dbl[CNT_W-1:0] - reload[CNT_W-1:0]) : dbl[CNT_W-1:0];
        lin_cnt = reload[CNT_W-1:0] - pos[CNT_W-1:0];
        sq_cnt  = reload[CNT_W-1:0] - fold_lo;

        count_now = (mode == MODE_SQUARE) ? sq_cnt : lin_cnt;

        if (!cfg_valid) begin
            out = 1'b0;
        end else begin
            unique case (mode)
                MODE_TERM:     out = (phase != PH_BEFORE);
                MODE_ONESHOT:  out = (phase == PH_BEFORE);
                MODE_RATE:     out = started && (pos == '0);
                MODE_SQUARE:   out = ({1'b0, pos} < half);
                default:       out = (phase == PH_AT);
            endcase
        end
    end

endmodule

// File: rtl/interval_counter.sv
module interval_counter
    import ict_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             mode_we,
    input  logic [2:0]       mode_sel,
    input  logic             count_we,
    input  logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] count_now,
    output logic             out
);
    logic           cfg_valid;
    mode_e          mode;
    logic [CNT_W:0] reload;
    logic           restart;
    logic           advance;
    logic [CNT_W:0] pos;
    phase_e         phase;
    logic           started;

    ict_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .gate      (gate),
        .mode_we   (mode_we),
        .mode_sel  (mode_sel),
        .count_we  (count_we),
        .count_val (count_val),
        .cfg_valid (cfg_valid),
        .mode      (mode),
        .reload    (reload),
        .restart   (restart),
        .advance   (advance)
    );

    ict_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .advance (advance),
        .mode    (mode),
        .reload  (reload),
        .pos     (pos),
        .phase   (phase),
        .started (started)
    );

    ict_shape #(.CNT_W(CNT_W)) u_shape (
        .cfg_valid (cfg_valid),
        .mode      (mode),
        .reload    (reload),
        .pos       (pos),
        .phase     (phase),
        .started   (started),
        .count_now (count_now),
        .out       (out)
    );

endmodule

// File: rtl/interval_counter_chk.sv
module interval_counter_chk
    import ict_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             gate,
    input logic             count_we,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] count_now,
    input logic             out,
    input logic             cfg_valid,
    input mode_e            mode,
    input logic [CNT_W:0]   reload,
    input logic             restart,
    input logic             advance
);
    localparam logic [CNT_W:0] ONE_R = 1;

    assert_load_readout_R3: assert property (@(posedge clk) disable iff (rst)
        count_we |=> (count_now == $past(count_val)));

    assert_term_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && mode == MODE_TERM && out && !restart) |=> out);

    assert_gate_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && (mode == MODE_TERM || mode == MODE_SWSTROBE) && !gate && !restart)
        |=> $stable(count_now));

    assert_rate_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && mode == MODE_RATE && out && advance && reload != ONE_R) |=> !out);

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && (mode == MODE_SWSTROBE || mode == MODE_HWSTROBE) && out && advance)
        |=> !out);

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> !out);

endmodule

bind interval_counter interval_counter_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .gate      (gate),
    .count_we  (count_we),
    .count_val (count_val),
    .count_now (count_now),
    .out       (out),
    .cfg_valid (cfg_valid),
    .mode      (mode),
    .reload    (reload),
    .restart   (restart),
    .advance   (advance)
);

// File: tb/test_interval_counter.sv
`timescale 1ns/1ps
module test_interval_counter;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic        mode_we = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        count_we = 1'b0;
    logic [15:0] count_val = 16'd0;
    logic [15:0] count_now;
    logic        out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    int m_n = 65536;
    int m_d = 0;
    int m_mode = 0;
    bit m_cfg = 0;
    bit m_gp = 0;
    bit g_lvl = 0;

    // Scoreboard queues
    string       q_tag[$];
    logic [15:0] q_cnt[$];
    logic        q_out[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_counter i_interval_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .gate      (gate),
        .mode_we   (mode_we),
        .mode_sel  (mode_sel),
        .count_we  (count_we),
        .count_val (count_val),
        .count_now (count_now),
        .out       (out)
    );

    task automatic push_expect(string tag);
        int c;
        bit o;
        if (m_mode == 2) begin
            c = m_n - (m_d % m_n);
            o = ((m_d % m_n) == 0) && (m_d != 0);
        end else if (m_mode == 3) begin
            c = m_n - ((2 * m_d) % m_n);
            o = (m_d % m_n) < ((m_n + 1) / 2);
        end else begin
            c = (m_n - m_d) & 16'hFFFF;
            if (m_mode == 0)      o = (m_d >= m_n);
            else if (m_mode == 1) o = (m_d < m_n);
            else                  o = (m_d == m_n);
        end
        if (!m_cfg) o = 0;
        q_tag.push_back(tag);
        q_cnt.push_back(c[15:0]);
        q_out.push_back(o);
    endtask

    task automatic step(bit t, bit g, bit mwe, bit [2:0] ms, bit cwe, bit [15:0] cv, string tag);
        bit rise, rs, gated, adv;
        tick = t; gate = g; mode_we = mwe; mode_sel = ms; count_we = cwe; count_val = cv;
        @(posedge clk);
        #1;
        rise  = g && !m_gp;
        rs    = cwe || mwe || (rise && m_cfg && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5));
        gated = (m_mode == 0) || (m_mode == 4);
        adv   = t && m_cfg && !rs && (g || !gated);
        if (mwe) begin
            m_cfg  = 1;
            m_mode = (ms > 5) ? int'(ms) - 4 : int'(ms);
        end
        if (cwe) m_n = (cv == 0) ? 65536 : int'(cv);
        if (rs) m_d = 0;
        else if (adv) m_d++;
        m_gp = g;
        push_expect(tag);
        #1;
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) step(1, g_lvl, 0, 0, 0, 0, tag);
    endtask

    task automatic idles(int n, string tag);
        for (int i = 0; i < n; i++) step(0, g_lvl, 0, 0, 0, 0, tag);
    endtask

    task automatic set_mode(bit [2:0] ms, string tag);
        step(0, g_lvl, 1, ms, 0, 0, tag);
    endtask

    task automatic load(bit [15:0] v, bit with_tick, string tag);
        step(with_tick, g_lvl, 0, 0, 1, v, tag);
    endtask

    task automatic set_gate(bit g, bit with_tick, string tag);
        g_lvl = g;
        step(with_tick, g_lvl, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_tag.size() > 0) begin
                string tg;
                logic [15:0] ec;
                logic eo;
                tg = q_tag.pop_front();
                ec = q_cnt.pop_front();
                eo = q_out.pop_front();
                checks++;
                if (count_now !== ec || out !== eo) begin
                    errors++;
                    $display("FAIL %s: count_now=%h out=%b expected count_now=%h out=%b",
                             tg, count_now, out, ec, eo);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;

        // R10: reset state, ticks ignored without a mode
        idles(1, "R10");
        g_lvl = 1;
        ticks(3, "R10");

        // R11: mode write restarts from held reload (65536 -> readout 0)
        set_mode(3'd0, "R11");
        ticks(2, "R11");

        // R3: load with coincident tick, tick not counted
        load(16'd5, 1, "R3");
        // R4: terminal count mode
        ticks(4, "R4");
        ticks(1, "R4");
        ticks(3, "R4");
        idles(2, "R4");

        // R5: gate low suspends counting in mode 0
        load(16'd7, 0, "R5");
        set_gate(0, 1, "R5");
        ticks(4, "R5");
        set_gate(1, 1, "R5");
        ticks(2, "R5");

        // R9: mode 4 strobe; R5: gating in mode 4
        set_mode(3'd4, "R9");
        load(16'd3, 0, "R9");
        ticks(2, "R9");
        idles(2, "R9");
        ticks(3, "R9");
        load(16'd4, 0, "R5");
        set_gate(0, 1, "R5");
        ticks(3, "R5");
        set_gate(1, 0, "R5");
        ticks(5, "R5");

        // R9: mode 5 strobe with gate retrigger
        set_mode(3'd5, "R9");
        load(16'd2, 0, "R9");
        ticks(3, "R9");
        set_gate(0, 1, "R9");
        set_gate(1, 1, "R9");
        ticks(3, "R9");

        // R6: one-shot with retrigger colliding with a tick
        set_mode(3'd1, "R6");
        load(16'd4, 0, "R6");
        ticks(5, "R6");
        set_gate(0, 1, "R6");
        set_gate(1, 1, "R6");
        ticks(2, "R6");
        // R3: reload mid-count with coincident tick
        load(16'd9, 1, "R3");
        ticks(3, "R3");

        // R7: rate generator
        set_mode(3'd2, "R7");
        load(16'd3, 0, "R7");
        ticks(7, "R7");
        set_gate(0, 1, "R7");
        set_gate(1, 1, "R7");
        ticks(4, "R7");
        load(16'd1, 0, "R7");
        ticks(3, "R7");

        // R2: code 6 acts as rate mode
        set_mode(3'd6, "R2");
        load(16'd4, 0, "R2");
        ticks(9, "R2");

        // R8: square wave, odd and even periods
        set_mode(3'd3, "R8");
        load(16'd5, 0, "R8");
        ticks(10, "R8");
        load(16'd6, 1, "R8");
        ticks(7, "R8");

        // R2: code 7 acts as square mode
        set_mode(3'd7, "R2");
        load(16'd4, 0, "R2");
        ticks(5, "R2");

        // R11: mode write keeps reload of 4 and restarts
        set_mode(3'd0, "R11");
        ticks(5, "R11");

        // R1: zero load means 65536 ticks
        load(16'd0, 0, "R1");
        ticks(65536, "R1");
        ticks(2, "R1");
        set_mode(3'd2, "R1");
        ticks(2, "R1");

        idles(2, "R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule